// File: doc/BRIEF.md
# Sixteen-Pin I/O Port Register Block

This block is the register side of one sixteen-pin general-purpose I/O port. A simple single-cycle register bus reads and writes eight word registers. Together they give each pin a four-bit mode field, an output data word, atomic set and clear writes, a synchronized view of the pad levels and a per-pin top-speed enable. From these registers the block derives, for every pin, an output value, an output enable, pull-up and pull-down requests and a top-speed request for the pad ring.

A lock engine can freeze the mode fields of chosen pins. Software must write a fixed three-step key pattern with an unchanged pin mask and then read the lock register. After that, the mode fields of the masked pins and the lock register itself cannot be changed until reset. Reads return `bus_rdata` combinationally from the current state for whatever `bus_addr` holds. A read strobe (`bus_rd`) only matters for the lock register, where it advances the lock engine.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every mode field is 4'b0100 (floating input), and the output data, top-speed and lock mask registers are zero. The lock is inactive, and every pad output enable, pull request and top-speed request is 0.
- R2: Word addresses are: 0 mode fields of pins 0-7, 1 mode fields of pins 8-15, 2 input status, 3 output data, 4 set, 5 clear, 6 lock, 7 top-speed enable. Pin p's mode field sits in word p/8 at bits 4*(p mod 8)+3 down to 4*(p mod 8), and reads back as written.
- R3: A write to address 3 loads the 16-bit output data word. It reads back and drives `pad_out`. The output data changes only on writes to addresses 3, 4 or 5.
- R4: A write to address 4 sets every output data bit whose bit is 1 in write bits 15:0 and clears every bit whose bit is 1 in write bits 31:16. Where a pin has both, set wins. Zero bits leave output data unchanged, and address 4 reads as zero.
- R5: A write to address 5 clears every output data bit whose write bit (15:0) is 1 and leaves the others. Address 5 reads as zero.
- R6: `pad_in` passes two flops before it appears in bits 15:0 of address 2. A change becomes visible after the second rising edge and not after the first. Writes to address 2 have no effect.
- R7: In a mode field, bits 1:0 non-zero mean output and 2'b00 means input. An output pin drives `pad_oe`=1, except when field bit 2 is set (open drain); then `pad_oe` is the inverse of its output data bit. An input pin with bits 3:2 = 2'b10 is a pull input: its output data bit 1 requests pull-up, 0 requests pull-down. Every other pin requests no pull and has `pad_oe`=0.
- R8: Address 7 holds a 16-bit top-speed enable. `pad_fast` of a pin is 1 only when its mode bits 1:0 are 2'b11 and its top-speed bit is set.
- R9: The lock register holds the pin mask in bits 15:0 and the key in bit 16. Writing key 1, then key 0, then key 1, all with the same mask, arms the engine. The next read of address 6 returns key 0 and makes the lock active; later reads return key 1.
- R10: A write to address 6 that breaks the key pattern or changes the mask returns the engine to idle. This includes any write made while armed. The lock then does not take effect, and reads return key 0.
- R11: While the lock is active, writes to addresses 0 and 1 leave the mode fields of masked pins unchanged and update the other pins. Writes to address 6 change neither mask nor key.
- R12: Once active, the lock stays active until reset, and reset releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; affects only the lock register |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_pu | output | 16 | Pull-up requests |
| pad_pd | output | 16 | Pull-down requests |
| pad_fast | output | 16 | Top-speed requests |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that each strobe lasts one cycle per access, so one lock read equals one engine step. The stimulus drives every access as a single-cycle pulse with an idle cycle after it, and never raises both strobes together. It changes `pad_in` only in dedicated steps followed by at least two edges, so a model can predict the status register without modelling metastability.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [2:0] {
      A_MODE_LO = 3'd0,
      A_MODE_HI = 3'd1,
      A_LEVELS  = 3'd2,
      A_DOUT    = 3'd3,
      A_SETCLR  = 3'd4,
      A_CLEAR   = 3'd5,
      A_LOCK    = 3'd6,
      A_TURBO   = 3'd7
   } reg_addr_e;

   typedef enum logic [2:0] {
      LK_IDLE  = 3'd0,
      LK_ONE   = 3'd1,
      LK_ZERO  = 3'd2,
      LK_ARMED = 3'd3,
      LK_HELD  = 3'd4
   } lock_state_e;

   localparam logic [3:0] MODE_RESET = 4'b0100;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
   import gpio_port_pkg::*;
#(
   parameter int PINS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_stb,
   input  logic            rd_stb,
   input  logic            wr_key,
   input  logic [PINS-1:0] wr_mask,
   output logic [PINS-1:0] mask_q,
   output logic            active
);

   lock_state_e state_q, state_d;
   logic        same_mask;

   assign same_mask = (wr_mask == mask_q);

   always_comb begin
      state_d = state_q;
      if (wr_stb) begin
         unique case (state_q)
            LK_IDLE:  state_d = wr_key ? LK_ONE : LK_IDLE;
            LK_ONE:   state_d = (!wr_key && same_mask) ? LK_ZERO : LK_IDLE;
            LK_ZERO:  state_d = (wr_key && same_mask) ? LK_ARMED : LK_IDLE;
            LK_ARMED: state_d = LK_IDLE;
            LK_HELD:  state_d = LK_HELD;
            default:  state_d = LK_IDLE;
         endcase
      end else if (rd_stb && state_q == LK_ARMED) begin
         state_d = LK_HELD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LK_IDLE;
         mask_q  <= '0;
      end else begin
         state_q <= state_d;
         if (wr_stb && state_q == LK_IDLE && wr_key)
            mask_q <= wr_mask;
      end
   end

   assign active = (state_q == LK_HELD);

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode #(
   parameter int FIELD_W = 4
) (
   input  logic [FIELD_W-1:0] mode,
   input  logic               dout_bit,
   input  logic               turbo_bit,
   output logic               oe,
   output logic               pu,
   output logic               pd,
   output logic               fast
);

   logic is_output;
   logic is_pull;

   assign is_output = |mode[1:0];
   assign is_pull   = !is_output && (mode[3:2] == 2'b10);

   assign oe   = is_output && (mode[2] ? !dout_bit : 1'b1);
   assign pu   = is_pull && dout_bit;
   assign pd   = is_pull && !dout_bit;
   assign fast = (mode[1:0] == 2'b11) && turbo_bit;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int         NUM_PINS    = 16,
   parameter int         FIELD_W     = 4,
   parameter int         BUS_W       = 32,
   parameter int         ADDR_W      = 3,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] MODE_INIT   = MODE_RESET
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_pd,
   output logic [NUM_PINS-1:0] pad_fast
);

   localparam int PINS_PER_REG = BUS_W / FIELD_W;
   localparam int MODE_REGS    = NUM_PINS / PINS_PER_REG;
   localparam int KEY_BIT      = NUM_PINS;
   localparam int CLR_LSB      = NUM_PINS;
   localparam int PAD_W        = BUS_W - NUM_PINS;

   if (FIELD_W != 4) begin : g_bad_field
      $error("mode field width must be 4");
   end
   if (BUS_W < 2 * NUM_PINS) begin : g_bad_bus
      $error("bus must carry set and clear halves");
   end
   if (MODE_REGS != 2 || NUM_PINS % PINS_PER_REG != 0) begin : g_bad_split
      $error("mode fields must split over exactly two words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("register map needs a 3-bit address");
   end

   reg_addr_e                     addr_e;
   logic [NUM_PINS*FIELD_W-1:0]   cfg_q;
   logic [NUM_PINS-1:0]           dout_q;
   logic [NUM_PINS-1:0]           turbo_q;
   logic [NUM_PINS-1:0]           levels;
   logic [NUM_PINS-1:0]           lock_mask;
   logic                          lock_active;
   logic                          wr_dout, wr_set, wr_clr, wr_turbo, wr_lock, rd_lock;
   logic [NUM_PINS-1:0]           set_bits, clr_bits;

   assign addr_e   = reg_addr_e'(bus_addr);
   assign wr_dout  = bus_wr && addr_e == A_DOUT;
   assign wr_set   = bus_wr && addr_e == A_SETCLR;
   assign wr_clr   = bus_wr && addr_e == A_CLEAR;
   assign wr_turbo = bus_wr && addr_e == A_TURBO;
   assign wr_lock  = bus_wr && addr_e == A_LOCK;
   assign rd_lock  = bus_rd && addr_e == A_LOCK;
   assign set_bits = bus_wdata[NUM_PINS-1:0];
   assign clr_bits = bus_wdata[CLR_LSB +: NUM_PINS];

   // per-pin mode fields, lockable
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
      localparam int          WORD = p / PINS_PER_REG;
      localparam int          LSB  = FIELD_W * (p % PINS_PER_REG);
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(WORD);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[p*FIELD_W +: FIELD_W] <= MODE_INIT;
         else if (bus_wr && bus_addr == WADDR && !(lock_active && lock_mask[p]))
            cfg_q[p*FIELD_W +: FIELD_W] <= bus_wdata[LSB +: FIELD_W];
      end
   end

   // output data with atomic set / clear, set has priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout_q <= '0;
      else if (wr_dout)
         dout_q <= set_bits;
      else if (wr_set)
         dout_q <= (dout_q & ~clr_bits) | set_bits;
      else if (wr_clr)
         dout_q <= dout_q & ~set_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        turbo_q <= '0;
      else if (wr_turbo) turbo_q <= bus_wdata[NUM_PINS-1:0];
   end

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (levels)
   );

   gpio_lock_ctrl #(
      .PINS (NUM_PINS)
   ) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_lock),
      .rd_stb  (rd_lock),
      .wr_key  (bus_wdata[KEY_BIT]),
      .wr_mask (bus_wdata[NUM_PINS-1:0]),
      .mask_q  (lock_mask),
      .active  (lock_active)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      gpio_pad_decode #(
         .FIELD_W (FIELD_W)
      ) u_dec (
         .mode      (cfg_q[p*FIELD_W +: FIELD_W]),
         .dout_bit  (dout_q[p]),
         .turbo_bit (turbo_q[p]),
         .oe        (pad_oe[p]),
         .pu        (pad_pu[p]),
         .pd        (pad_pd[p]),
         .fast      (pad_fast[p])
      );
   end

   assign pad_out = dout_q;

   always_comb begin
      unique case (addr_e)
         A_MODE_LO: bus_rdata = cfg_q[0 +: BUS_W];
         A_MODE_HI: bus_rdata = cfg_q[BUS_W +: BUS_W];
         A_LEVELS:  bus_rdata = {{PAD_W{1'b0}}, levels};
         A_DOUT:    bus_rdata = {{PAD_W{1'b0}}, dout_q};
         A_LOCK:    bus_rdata = {{(PAD_W-1){1'b0}}, lock_active, lock_mask};
         A_TURBO:   bus_rdata = {{PAD_W{1'b0}}, turbo_q};
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 16,
   parameter int FIELD_W  = 4,
   parameter int BUS_W    = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_wr,
   input logic                        bus_rd,
   input logic [2:0]                  bus_addr,
   input logic [BUS_W-1:0]            bus_wdata,
   input logic [NUM_PINS-1:0]         pad_out,
   input logic [NUM_PINS-1:0]         pad_oe,
   input logic [NUM_PINS-1:0]         pad_pu,
   input logic [NUM_PINS-1:0]         pad_pd,
   input logic [NUM_PINS-1:0]         pad_fast,
   input logic [NUM_PINS*FIELD_W-1:0] cfg_q,
   input logic [NUM_PINS-1:0]         lock_mask,
   input logic                        lock_active
);

   logic [NUM_PINS*FIELD_W-1:0] mask_wide;
   logic                        touch_dout;
   logic                        cfg_write;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_wide
      assign mask_wide[p*FIELD_W +: FIELD_W] = {FIELD_W{lock_mask[p]}};
   end

   assign touch_dout = bus_wr && (bus_addr == A_DOUT || bus_addr == A_SETCLR || bus_addr == A_CLEAR);
   assign cfg_write  = bus_wr && (bus_addr == A_MODE_LO || bus_addr == A_MODE_HI);

   assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_SETCLR |=>
         (pad_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]));

   assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_CLEAR |=>
         (pad_out & $past(bus_wdata[NUM_PINS-1:0])) == '0);

   assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !touch_dout |=> $stable(pad_out));

   assert_pull_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_pd) == '0) && ((pad_oe & (pad_pu | pad_pd)) == '0));

   assert_fast_no_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_fast & (pad_pu | pad_pd)) == '0);

   assert_lock_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_active) |-> $past(bus_rd && bus_addr == A_LOCK));

   assert_lock_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active && cfg_write |=> ((cfg_q ^ $past(cfg_q)) & mask_wide) == '0);

   assert_lock_mask_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |=> $stable(lock_mask));

   assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |=> lock_active);

endmodule

bind gpio_port_regs gpio_port_regs_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .pad_pu      (pad_pu),
   .pad_pd      (pad_pd),
   .pad_fast    (pad_fast),
   .cfg_q       (cfg_q),
   .lock_mask   (lock_mask),
   .lock_active (lock_active)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pad_pu, pad_pd, pad_fast;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [3:0]  m_cfg [16];
   logic [15:0] m_out, m_fast, m_mask;
   int          m_st;   // 0 idle, 1 one, 2 zero, 3 armed, 4 held

   always #10 clk = ~clk;

   gpio_port_regs u_gpio_port_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .pad_pu    (pad_pu),
      .pad_pd    (pad_pd),
      .pad_fast  (pad_fast)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int p = 0; p < 16; p++) m_cfg[p] = 4'b0100;
      m_out = '0; m_fast = '0; m_mask = '0; m_st = 0;
   endtask

   function automatic logic [31:0] m_word(input int w);
      logic [31:0] r;
      for (int k = 0; k < 8; k++) r[4*k +: 4] = m_cfg[8*w + k];
      return r;
   endfunction

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_word(0);
         3'd1: return m_word(1);
         3'd2: return {16'h0, pad_in};
         3'd3: return {16'h0, m_out};
         3'd6: return {15'h0, m_st == 4, m_mask};
         3'd7: return {16'h0, m_fast};
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_write(input logic [2:0] a, input logic [31:0] d);
      case (a)
         3'd0, 3'd1: for (int k = 0; k < 8; k++) begin
            if (!(m_st == 4 && m_mask[8*a + k])) m_cfg[8*a + k] = d[4*k +: 4];
         end
         3'd3: m_out = d[15:0];
         3'd4: m_out = (m_out & ~d[31:16]) | d[15:0];
         3'd5: m_out = m_out & ~d[15:0];
         3'd7: m_fast = d[15:0];
         3'd6: case (m_st)
            0: if (d[16]) begin m_st = 1; m_mask = d[15:0]; end
            1: m_st = (!d[16] && d[15:0] == m_mask) ? 2 : 0;
            2: m_st = (d[16] && d[15:0] == m_mask) ? 3 : 0;
            3: m_st = 0;
            default: ;
         endcase
         default: ;
      endcase
   endtask

   function automatic logic [15:0] e_oe();
      logic [15:0] r;
      for (int p = 0; p < 16; p++)
         r[p] = (m_cfg[p][1:0] != 2'b00) && (m_cfg[p][2] ? !m_out[p] : 1'b1);
      return r;
   endfunction

   function automatic logic [15:0] e_pull(input logic up);
      logic [15:0] r;
      for (int p = 0; p < 16; p++)
         r[p] = (m_cfg[p][1:0] == 2'b00) && (m_cfg[p][3:2] == 2'b10) && (m_out[p] == up);
      return r;
   endfunction

   function automatic logic [15:0] e_fast();
      logic [15:0] r;
      for (int p = 0; p < 16; p++) r[p] = (m_cfg[p][1:0] == 2'b11) && m_fast[p];
      return r;
   endfunction

   task automatic check_pads();
      chk("R3 pad_out", {16'h0, pad_out}, {16'h0, m_out});
      chk("R7 pad_oe", {16'h0, pad_oe}, {16'h0, e_oe()});
      chk("R7 pad_pu", {16'h0, pad_pu}, {16'h0, e_pull(1'b1)});
      chk("R7 pad_pd", {16'h0, pad_pd}, {16'h0, e_pull(1'b0)});
      chk("R8 pad_fast", {16'h0, pad_fast}, {16'h0, e_fast()});
   endtask

   task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic do_rd(input string req, input logic [2:0] a);
      logic [31:0] got, exp;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp = m_read(a);
      #1 got = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      if (a == 3'd6 && m_st == 3) m_st = 4;
      chk(req, got, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) do_rd("R1 reset readback", 3'(a));
      check_pads();

      // R2 layout: pin 9 push-pull top speed, R8 top-speed enable
      do_wr(3'd1, 32'h4444_4434);
      do_rd("R2 mode hi readback", 3'd1);
      chk("R2 pin9 oe", {31'h0, pad_oe[9]}, 32'h1);
      chk("R8 fast without enable", {31'h0, pad_fast[9]}, 32'h0);
      do_wr(3'd7, 32'h0000_0200);
      chk("R8 fast with enable", {31'h0, pad_fast[9]}, 32'h1);
      do_rd("R8 turbo readback", 3'd7);

      // R3 full output write
      do_wr(3'd3, 32'hFFFF_A5C3);
      do_rd("R3 dout readback", 3'd3);
      check_pads();

      // R4 set wins over clear in the same write
      do_wr(3'd4, 32'h00FF_0F0F);
      chk("R4 set wins", {16'h0, pad_out}, {16'h0, 16'hA5CF & 16'hFF00 | 16'h0F0F});
      do_rd("R4 set reg reads zero", 3'd4);

      // R5 clear
      do_wr(3'd5, 32'hFFFF_0F00);
      chk("R5 clear", {16'h0, pad_out}, {16'h0, m_out});
      do_rd("R5 clear reg reads zero", 3'd5);

      // R7 pull input on pin 0, open drain on pin 1
      do_wr(3'd0, 32'h4444_4458);
      do_wr(3'd4, 32'h0000_0003);
      chk("R7 pull up", {31'h0, pad_pu[0]}, 32'h1);
      chk("R7 open drain high", {31'h0, pad_oe[1]}, 32'h0);
      do_wr(3'd5, 32'h0000_0003);
      chk("R7 pull down", {31'h0, pad_pd[0]}, 32'h1);
      chk("R7 open drain low", {31'h0, pad_oe[1]}, 32'h1);
      check_pads();

      // R6 synchronizer latency
      @(negedge clk);
      bus_addr = 3'd2;
      pad_in = 16'hBEEF;
      @(negedge clk);
      chk("R6 not after one edge", bus_rdata, 32'h0);
      @(negedge clk);
      chk("R6 after two edges", bus_rdata, 32'h0000_BEEF);
      do_wr(3'd2, 32'h1234_5678);
      do_rd("R6 level write ignored", 3'd2);

      // R9 lock sequence on pins 4-7
      do_wr(3'd6, 32'h0001_00F0);
      do_wr(3'd6, 32'h0000_00F0);
      do_wr(3'd6, 32'h0001_00F0);
      do_rd("R9 first read key 0", 3'd6);
      do_rd("R9 second read key 1", 3'd6);
      chk("R9 key bit set", {31'h0, m_st == 4}, 32'h1);

      // R11 masked fields frozen, lock read-only
      do_wr(3'd0, 32'h0000_0000);
      do_rd("R11 masked pins frozen", 3'd0);
      do_wr(3'd6, 32'h0000_FFFF);
      do_rd("R11 lock reg read-only", 3'd6);
      check_pads();

      // R12 reset releases the lock
      do_reset();
      do_rd("R12 lock released", 3'd6);
      do_wr(3'd0, 32'h1111_1111);
      do_rd("R12 fields writable", 3'd0);

      // R10 changed mask breaks sequence
      do_wr(3'd6, 32'h0001_000F);
      do_wr(3'd6, 32'h0000_000F);
      do_wr(3'd6, 32'h0001_00FF);
      do_rd("R10 changed mask key 0", 3'd6);
      do_rd("R10 still key 0", 3'd6);
      // R10 write while armed
      do_wr(3'd6, 32'h0001_000F);
      do_wr(3'd6, 32'h0000_000F);
      do_wr(3'd6, 32'h0001_000F);
      do_wr(3'd6, 32'h0001_000F);
      do_rd("R10 armed write aborts", 3'd6);
      do_wr(3'd0, 32'h2222_2222);
      do_rd("R10 no lock took effect", 3'd0);

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [2:0]  a;
         logic [31:0] d;
         a = 3'($urandom % 8);
         d = $urandom;
         if (a == 3'd6) d = {15'h0, d[16], (d[0] ? 16'h0F00 : 16'h00F0)};
         if ($urandom % 3 == 0) begin
            do_rd("R2 random readback", a);
         end else begin
            do_wr(a, d);
            check_pads();
         end
         if (i % 150 == 149) begin
            @(negedge clk);
            pad_in = 16'($urandom);
            repeat (2) @(negedge clk);
            do_rd("R6 random levels", 3'd2);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule